// File: doc/BRIEF.md
# FIFO UART with Automatic Flow Control

This block is the data path of an enhanced serial port. Bytes written by the register side enter an 8-entry transmit queue and leave one at a time on the TX line as 8N1 frames: a low start bit, eight data bits least significant first, and a high stop bit. Each bit lasts 16 periods of an externally supplied 16x baud tick. Frames arriving on the RX line are sampled at mid-bit, deframed and queued in an 8-entry receive queue that the register side drains.

Flow control is built in. With automatic handshaking on, the transmitter starts a new character only while the peer's CTS input is low, and RTS is withdrawn once the receive queue fills to a programmable trigger level. RTS stays withdrawn until the queue has been drained completely. This hysteresis stops the line from chattering when the reader empties the queue slowly. The block also raises a data-available interrupt at the trigger level, a receive timeout interrupt for stale data, an overrun flag, a CTS-change flag and two transmit-empty flags. With queueing disabled, both directions act as single-byte holding registers.

Both data streams use valid/ready. On the write side, a byte is taken on any clock edge where `tx_valid` and `tx_ready` are both high. `tx_ready` is low while the transmit queue is full, and the producer must then hold its byte. On the read side, `rx_data` is valid whenever `rx_valid` is high, and the head byte is removed on an edge where `rx_valid` and `rx_ready` are both high. The line itself cannot be stalled, so a character that completes against a full receive queue is lost.

Top module: `fc_uart`

## Requirements
- R1: After reset, `rts_n` and `tx_line` are 1, `tx_ready`, `tx_empty` and `tx_all_empty` are 1, and `rx_valid`, `irq_rx_avail`, `irq_rx_tout`, `irq_cts_chg` and `overrun` are 0.
- R2: Accepted bytes are sent in acceptance order as 8N1 frames: start bit 0, then data bit 0 through bit 7, then stop bit 1, each bit 16 baud ticks long. `tx_ready` is 0 while 8 bytes are queued and waiting.
- R3: A received 8N1 frame is presented as `rx_data` with `rx_valid` = 1 in arrival order. Each handshake pops exactly one byte.
- R4: `irq_rx_avail` is 1 exactly while the receive count is at least the trigger level. `rx_trig` encodes 00→1, 01→2, 10→4 and 11→7 bytes.
- R5: With `auto_flow` = 1 and `rts_req` = 1, `rts_n` is 0 while the receive queue is empty. `rts_n` goes to 1 when the count reaches the trigger level and stays 1 until the queue is empty again, even if the count drops below the trigger level first.
- R6: With `auto_flow` = 1, a character starts only while the synchronised `cts_n` is 0. Raising `cts_n` mid-character lets that character finish and holds back the following ones.
- R7: A change on `cts_n` sets `irq_cts_chg` only while `auto_flow` = 0. `cts_ack` clears the flag.
- R8: A `tx_flush` or `rx_flush` pulse empties its queue. It does not disturb the character currently being shifted out or in.
- R9: With `fifo_en` = 0, each queue holds one byte and the trigger level is 1 whatever `rx_trig` holds.
- R10: `irq_rx_tout` rises when the receive queue holds data and 640 baud ticks (4 character times) have passed without a received character or a pop. Each received character and each pop restarts the count, and a pop clears the interrupt.
- R11: `tx_empty` is 1 when the transmit queue is empty. `tx_all_empty` additionally requires the transmit shifter to be idle.
- R12: When a character completes while the receive queue is full, `overrun` is set, the character is dropped and the queued bytes are kept. `ovr_ack` clears `overrun`.
- R13: With `auto_flow` = 0, `rts_n` is the inverse of `rts_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| fifo_en | input | 1 | 1: 8-entry queues, 0: one-byte holding registers |
| rx_trig | input | 2 | Receive trigger level select |
| auto_flow | input | 1 | Enables automatic RTS/CTS handshaking |
| rts_req | input | 1 | Software request to assert RTS |
| tx_flush | input | 1 | Pulse that empties the transmit queue |
| rx_flush | input | 1 | Pulse that empties the receive queue |
| tx_valid | input | 1 | Write-side byte valid |
| tx_ready | output | 1 | Transmit queue can accept a byte |
| tx_data | input | 8 | Byte to transmit |
| rx_valid | output | 1 | Receive queue holds a byte |
| rx_ready | input | 1 | Read side takes the head byte |
| rx_data | output | 8 | Head byte of the receive queue |
| cts_n | input | 1 | Peer clear-to-send, active low, asynchronous |
| rx_line | input | 1 | Serial input, asynchronous |
| cts_ack | input | 1 | Clears `irq_cts_chg` |
| ovr_ack | input | 1 | Clears `overrun` |
| rts_n | output | 1 | Request-to-send, active low |
| tx_line | output | 1 | Serial output |
| irq_rx_avail | output | 1 | Receive count at or above trigger level |
| irq_rx_tout | output | 1 | Receive timeout |
| irq_cts_chg | output | 1 | CTS changed while handshaking was off |
| overrun | output | 1 | A character was lost to a full queue |
| tx_empty | output | 1 | Transmit queue empty |
| tx_all_empty | output | 1 | Transmit queue empty and shifter idle |

## Verification
The transmit path is tried with random bytes in three ways: queued behind a high CTS until the queue is full, paused by CTS in the middle of a character, and flushed during a character. A bench decoder on the line checks frame shape and byte order, and so shows whether the gate acts only between characters. The receive path is tried with random frames at every trigger level, which separates the level threshold from the RTS release at empty. A deliberate ninth frame checks that an overrun drops the new byte rather than an old one, and a second pass repeats the key cases with queueing disabled. Timed idle gaps, with and without an intermediate character, check that the timeout reloads on each arrival instead of counting from the first byte.

// File: rtl/uart_fc_pkg.sv
package uart_fc_pkg;
  localparam int BIT_TICKS  = 16;
  localparam int DATA_BITS  = 8;
  localparam int FRAME_BITS = DATA_BITS + 2;

  typedef enum logic [1:0] {
    TRIG_ONE  = 2'b00,
    TRIG_TWO  = 2'b01,
    TRIG_HALF = 2'b10,
    TRIG_HIGH = 2'b11
  } rx_trig_e;

  typedef enum logic {
    LINE_IDLE = 1'b0,
    LINE_BUSY = 1'b1
  } line_st_e;
endpackage

// File: rtl/uart_fc_fifo.sv
module uart_fc_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             single,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic [CW-1:0]    count,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty = (count == '0);
  assign full  = single ? !empty : (count == CW'(DEPTH));
  assign dout  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= nxt(wr_ptr);
      if (pop)  rd_ptr <= nxt(rd_ptr);
      unique case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R12: the producer must drop, never write into a full queue
  assert_no_push_when_full_R12: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R3: a pop is only issued on a non-empty queue
  assert_no_pop_when_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/uart_fc_tx.sv
module uart_fc_tx
  import uart_fc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 go,
  input  logic                 avail,
  input  logic [DATA_BITS-1:0] din,
  output logic                 load,
  output logic                 line,
  output logic                 busy
);
  localparam int TW = $clog2(BIT_TICKS);
  localparam int BW = $clog2(FRAME_BITS);

  line_st_e              st;
  logic [FRAME_BITS-1:0] shreg;
  logic [TW-1:0]         tcnt;
  logic [BW-1:0]         bcnt;

  assign load = (st == LINE_IDLE) && avail && go;
  assign busy = (st == LINE_BUSY);
  assign line = shreg[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= LINE_IDLE;
      shreg <= '1;
      tcnt  <= '0;
      bcnt  <= '0;
    end else if (load) begin
      st    <= LINE_BUSY;
      shreg <= {1'b1, din, 1'b0};
      tcnt  <= '0;
      bcnt  <= '0;
    end else if (busy && tick) begin
      if (tcnt == TW'(BIT_TICKS - 1)) begin
        tcnt  <= '0;
        shreg <= {1'b1, shreg[FRAME_BITS-1:1]};
        if (bcnt == BW'(FRAME_BITS - 1)) st <= LINE_IDLE;
        else                             bcnt <= bcnt + 1'b1;
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end

  // R2: the line rests high whenever no character is being shifted
  assert_idle_line_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> line);
endmodule

// File: rtl/uart_fc_rx.sv
module uart_fc_rx
  import uart_fc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 line,
  output logic                 done,
  output logic [DATA_BITS-1:0] data
);
  localparam int TW = $clog2(BIT_TICKS);
  localparam int BW = $clog2(DATA_BITS + 1);

  line_st_e      st;
  logic [TW-1:0] tcnt;
  logic [BW-1:0] bcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= LINE_IDLE;
      tcnt <= '0;
      bcnt <= '0;
      data <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        if (st == LINE_IDLE) begin
          if (line) begin
            tcnt <= '0;
          end else if (tcnt == TW'(BIT_TICKS / 2 - 1)) begin
            st   <= LINE_BUSY;
            tcnt <= '0;
            bcnt <= '0;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end else if (tcnt == TW'(BIT_TICKS - 1)) begin
          tcnt <= '0;
          if (bcnt == BW'(DATA_BITS)) begin
            done <= 1'b1;
            st   <= LINE_IDLE;
          end else begin
            data <= {line, data[DATA_BITS-1:1]};
            bcnt <= bcnt + 1'b1;
          end
        end else begin
          tcnt <= tcnt + 1'b1;
        end
      end
    end
  end

  // R3: each frame yields a single completion pulse
  assert_done_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/fc_uart.sv
module fc_uart
  import uart_fc_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int TOUT_CHARS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 baud_tick,
  input  logic                 fifo_en,
  input  logic [1:0]           rx_trig,
  input  logic                 auto_flow,
  input  logic                 rts_req,
  input  logic                 tx_flush,
  input  logic                 rx_flush,
  input  logic                 tx_valid,
  output logic                 tx_ready,
  input  logic [DATA_BITS-1:0] tx_data,
  output logic                 rx_valid,
  input  logic                 rx_ready,
  output logic [DATA_BITS-1:0] rx_data,
  input  logic                 cts_n,
  input  logic                 rx_line,
  input  logic                 cts_ack,
  input  logic                 ovr_ack,
  output logic                 rts_n,
  output logic                 tx_line,
  output logic                 irq_rx_avail,
  output logic                 irq_rx_tout,
  output logic                 irq_cts_chg,
  output logic                 overrun,
  output logic                 tx_empty,
  output logic                 tx_all_empty
);
  localparam int CW         = $clog2(FIFO_DEPTH + 1);
  localparam int TOUT_TICKS = TOUT_CHARS * FRAME_BITS * BIT_TICKS;
  localparam int OW         = $clog2(TOUT_TICKS + 1);

  // Input synchronisers
  logic [1:0] rx_sync, cts_sync;
  logic       cts_prev;
  logic       rx_s, cts_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sync  <= 2'b11;
      cts_sync <= 2'b11;
      cts_prev <= 1'b1;
    end else begin
      rx_sync  <= {rx_sync[0], rx_line};
      cts_sync <= {cts_sync[0], cts_n};
      cts_prev <= cts_s;
    end
  end
  assign rx_s  = rx_sync[1];
  assign cts_s = cts_sync[1];

  // Transmit path
  logic [DATA_BITS-1:0] txq_dout;
  logic [CW-1:0]        txq_count;
  logic txq_full, txq_empty, tx_push, tx_load, tx_busy;

  assign tx_ready = !txq_full;
  assign tx_push  = tx_valid && tx_ready;

  uart_fc_fifo #(.WIDTH(DATA_BITS), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush), .single(!fifo_en),
    .push(tx_push), .din(tx_data), .pop(tx_load), .dout(txq_dout),
    .count(txq_count), .full(txq_full), .empty(txq_empty));

  uart_fc_tx u_tx (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick),
    .go(!auto_flow || !cts_s), .avail(!txq_empty && !tx_flush),
    .din(txq_dout), .load(tx_load), .line(tx_line), .busy(tx_busy));

  assign tx_empty     = txq_empty;
  assign tx_all_empty = txq_empty && !tx_busy;

  // Receive path
  logic [DATA_BITS-1:0] rx_word;
  logic [CW-1:0]        rxq_count, level;
  logic rx_done, rxq_full, rxq_empty, rx_push, rx_pop;

  uart_fc_rx u_rx (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .line(rx_s),
    .done(rx_done), .data(rx_word));

  assign rx_push  = rx_done && !rxq_full;
  assign rx_pop   = rx_valid && rx_ready;
  assign rx_valid = !rxq_empty;

  uart_fc_fifo #(.WIDTH(DATA_BITS), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush), .single(!fifo_en),
    .push(rx_push), .din(rx_word), .pop(rx_pop), .dout(rx_data),
    .count(rxq_count), .full(rxq_full), .empty(rxq_empty));

  // Trigger level
  always_comb begin
    unique case (rx_trig_e'(rx_trig))
      TRIG_ONE:  level = CW'(1);
      TRIG_TWO:  level = CW'(2);
      TRIG_HALF: level = CW'(FIFO_DEPTH / 2);
      default:   level = CW'(FIFO_DEPTH - 1);
    endcase
    if (!fifo_en) level = CW'(1);
  end
  assign irq_rx_avail = (rxq_count >= level);

  // RTS with hysteresis: withdrawn at trigger, restored at empty
  logic rts_hold, rts_block;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                rts_hold <= 1'b0;
    else if (rxq_count == '0)  rts_hold <= 1'b0;
    else if (irq_rx_avail)     rts_hold <= 1'b1;
  end
  assign rts_block = rts_hold || irq_rx_avail;
  assign rts_n     = !(rts_req && !(auto_flow && rts_block));

  // Receive timeout
  logic [OW-1:0] tout_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      tout_cnt <= '0;
    else if (rx_push || rx_pop || rxq_empty || rx_flush)
      tout_cnt <= '0;
    else if (baud_tick && tout_cnt != OW'(TOUT_TICKS))
      tout_cnt <= tout_cnt + 1'b1;
  end
  assign irq_rx_tout = (tout_cnt == OW'(TOUT_TICKS)) && !rxq_empty;

  // Sticky flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      overrun     <= 1'b0;
      irq_cts_chg <= 1'b0;
    end else begin
      if (rx_done && rxq_full) overrun <= 1'b1;
      else if (ovr_ack)        overrun <= 1'b0;
      if ((cts_s != cts_prev) && !auto_flow) irq_cts_chg <= 1'b1;
      else if (cts_ack)                      irq_cts_chg <= 1'b0;
    end
  end

  // R5: once withdrawn, RTS stays withdrawn while data remains queued
  assert_rts_hysteresis_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_flow && rts_req && $past(auto_flow && rts_req) && $past(rts_n)
     && $past(rxq_count) != '0 && rxq_count != '0) |-> rts_n);
  // R6: no character is launched against an inactive CTS
  assert_cts_gates_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_flow && cts_s) |-> !tx_load);
  // R7: the CTS flag cannot rise under automatic handshaking
  assert_no_cts_flag_auto_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_flow && !irq_cts_chg) |=> !irq_cts_chg);
  // R12: a character completing into a full queue is flagged
  assert_overrun_set_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rxq_full) |=> overrun);
  // R10: the timeout never reports without queued data
  assert_tout_needs_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx_tout |-> rx_valid);
  // R11: the all-empty flag implies the queue-empty flag
  assert_all_empty_implies_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_all_empty |-> tx_empty);
endmodule

// File: tb/fc_uart_bench.sv
`timescale 1ns/100ps
module fc_uart_bench;
  logic clk = 1'b0;
  logic rst_n, baud_tick, fifo_en, auto_flow, rts_req, tx_flush, rx_flush;
  logic tx_valid, tx_ready, rx_valid, rx_ready, cts_n, rx_line, cts_ack, ovr_ack;
  logic [1:0] rx_trig;
  logic [7:0] tx_data, rx_data;
  logic rts_n, tx_line, irq_rx_avail, irq_rx_tout, irq_cts_chg, overrun;
  logic tx_empty, tx_all_empty;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] mon_q[$];
  logic [7:0] exp_q[$];

  always #2.5 clk = ~clk;

  initial baud_tick = 1'b0;
  always @(posedge clk) baud_tick <= ~baud_tick;

  fc_uart u_fc_uart (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .fifo_en(fifo_en),
    .rx_trig(rx_trig), .auto_flow(auto_flow), .rts_req(rts_req),
    .tx_flush(tx_flush), .rx_flush(rx_flush), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data), .cts_n(cts_n), .rx_line(rx_line),
    .cts_ack(cts_ack), .ovr_ack(ovr_ack), .rts_n(rts_n), .tx_line(tx_line),
    .irq_rx_avail(irq_rx_avail), .irq_rx_tout(irq_rx_tout),
    .irq_cts_chg(irq_cts_chg), .overrun(overrun), .tx_empty(tx_empty),
    .tx_all_empty(tx_all_empty));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_level(input logic [1:0] trig, input logic fen);
    if (!fen) return 1;
    case (trig)
      2'b00:   return 1;
      2'b01:   return 2;
      2'b10:   return 4;
      default: return 7;
    endcase
  endfunction

  function automatic logic [7:0] rnd_byte();
    return 8'($urandom());
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_rx(input logic [7:0] b);
    logic [9:0] fr;
    fr = {1'b1, b, 1'b0};
    for (int i = 0; i < 10; i++) begin
      rx_line = fr[i];
      cyc(32);
    end
  endtask

  task automatic pop_rx(input string tag, input logic [7:0] exp);
    @(negedge clk);
    chk({tag, " rx_valid"}, rx_valid, 1'b1);
    chk({tag, " rx_data"}, rx_data, exp);
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  task automatic push_tx(input logic [7:0] b);
    @(negedge clk);
    tx_valid = 1'b1;
    tx_data  = b;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic pulse_rx_flush();
    @(negedge clk); rx_flush = 1'b1;
    @(negedge clk); rx_flush = 1'b0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // Line decoder for the transmitter (R2)
  initial begin
    logic [7:0] b;
    forever begin
      @(negedge tx_line);
      repeat (16) @(posedge clk);
      #1;
      chk("R2 start bit", tx_line, 1'b0);
      b = '0;
      for (int i = 0; i < 8; i++) begin
        repeat (32) @(posedge clk);
        #1;
        b[i] = tx_line;
      end
      repeat (32) @(posedge clk);
      #1;
      chk("R2 stop bit", tx_line, 1'b1);
      mon_q.push_back(b);
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] b, b2;
    int lv;
    void'($urandom(32'd7331));
    rst_n = 1'b0; fifo_en = 1'b1; rx_trig = 2'b00; auto_flow = 1'b0; rts_req = 1'b0;
    tx_flush = 1'b0; rx_flush = 1'b0; tx_valid = 1'b0; tx_data = '0; rx_ready = 1'b0;
    cts_n = 1'b1; rx_line = 1'b1; cts_ack = 1'b0; ovr_ack = 1'b0;
    cyc(10);
    rst_n = 1'b1;
    cyc(2);

    // R1 reset state
    chk("R1 rts_n", rts_n, 1'b1);
    chk("R1 tx_line", tx_line, 1'b1);
    chk("R1 tx_ready", tx_ready, 1'b1);
    chk("R1 tx_empty", tx_empty, 1'b1);
    chk("R1 tx_all_empty", tx_all_empty, 1'b1);
    chk("R1 rx_valid", rx_valid, 1'b0);
    chk("R1 irqs", {irq_rx_avail, irq_rx_tout, irq_cts_chg, overrun}, 4'b0);

    // R13 plain RTS
    rts_req = 1'b1; cyc(1);
    chk("R13 rts follows req", rts_n, 1'b0);
    rts_req = 1'b0; cyc(1);
    chk("R13 rts released", rts_n, 1'b1);

    // R2/R6: fill behind high CTS, then release
    auto_flow = 1'b1; cts_n = 1'b1; cyc(5);
    exp_q.delete(); mon_q.delete();
    for (int i = 0; i < 8; i++) begin
      b = rnd_byte(); exp_q.push_back(b); push_tx(b);
    end
    cyc(5);
    chk("R2 tx_ready low when full", tx_ready, 1'b0);
    chk("R11 tx_empty with queue", tx_empty, 1'b0);
    chk("R11 all_empty with queue", tx_all_empty, 1'b0);
    cyc(400);
    chk("R6 nothing sent under high CTS", mon_q.size(), 0);
    cts_n = 1'b0;
    cyc(8 * 320 + 200);
    chk("R2 frame count", mon_q.size(), 8);
    for (int i = 0; i < 8 && i < mon_q.size(); i++) chk("R2 byte order", mon_q[i], exp_q[i]);
    chk("R11 all_empty after drain", tx_all_empty, 1'b1);

    // R6 pause mid-character
    exp_q.delete(); mon_q.delete();
    for (int i = 0; i < 3; i++) begin
      b = rnd_byte(); exp_q.push_back(b); push_tx(b);
    end
    cyc(40);
    cts_n = 1'b1;
    cyc(1000);
    chk("R6 only current char finishes", mon_q.size(), 1);
    chk("R11 tx_empty while paused", tx_empty, 1'b0);
    cts_n = 1'b0;
    cyc(2 * 320 + 150);
    chk("R6 resumed count", mon_q.size(), 3);
    for (int i = 0; i < 3 && i < mon_q.size(); i++) chk("R6 resumed order", mon_q[i], exp_q[i]);

    // R11 flags during a single character
    mon_q.delete();
    b = rnd_byte(); push_tx(b);
    cyc(30);
    chk("R11 tx_empty while shifting", tx_empty, 1'b1);
    chk("R11 all_empty while shifting", tx_all_empty, 1'b0);
    cyc(400);
    chk("R11 all_empty idle", tx_all_empty, 1'b1);
    chk("R2 single byte", (mon_q.size() > 0) ? mon_q[0] : 8'hxx, b);

    // R8 transmit flush keeps the shifting character
    mon_q.delete();
    b = rnd_byte(); push_tx(b); push_tx(rnd_byte()); push_tx(rnd_byte());
    cyc(30);
    @(negedge clk); tx_flush = 1'b1; @(negedge clk); tx_flush = 1'b0;
    cyc(3);
    chk("R8 tx flush empties", tx_empty, 1'b1);
    chk("R8 tx flush keeps shifter", tx_all_empty, 1'b0);
    cyc(1000);
    chk("R8 one char after flush", mon_q.size(), 1);
    chk("R8 surviving char", (mon_q.size() > 0) ? mon_q[0] : 8'hxx, b);

    // R7 CTS change flag
    auto_flow = 1'b0; cts_n = 1'b1; cyc(5);
    chk("R7 flag when handshake off", irq_cts_chg, 1'b1);
    @(negedge clk); cts_ack = 1'b1; @(negedge clk); cts_ack = 1'b0;
    cyc(2);
    chk("R7 ack clears", irq_cts_chg, 1'b0);
    auto_flow = 1'b1; cts_n = 1'b0; cyc(5);
    chk("R7 no flag when handshake on", irq_cts_chg, 1'b0);

    // R3/R4/R5 at every trigger level
    rts_req = 1'b1;
    for (int t = 0; t < 4; t++) begin
      rx_trig = 2'(t);
      lv = exp_level(2'(t), 1'b1);
      exp_q.delete();
      cyc(2);
      chk("R5 rts active when empty", rts_n, 1'b0);
      for (int i = 0; i < lv - 1; i++) begin
        b = rnd_byte(); exp_q.push_back(b); send_rx(b);
      end
      if (lv > 1) begin
        chk("R4 below trigger", irq_rx_avail, 1'b0);
        chk("R5 rts active below trigger", rts_n, 1'b0);
      end
      b = rnd_byte(); exp_q.push_back(b); send_rx(b);
      chk("R4 at trigger", irq_rx_avail, 1'b1);
      chk("R5 rts withdrawn at trigger", rts_n, 1'b1);
      pop_rx("R3 first pop", exp_q.pop_front());
      if (lv > 1) begin
        chk("R4 below trigger after pop", irq_rx_avail, 1'b0);
        chk("R5 rts held after pop", rts_n, 1'b1);
      end
      while (exp_q.size() > 0) pop_rx("R3 drain", exp_q.pop_front());
      cyc(2);
      chk("R5 rts restored at empty", rts_n, 1'b0);
      chk("R3 empty after drain", rx_valid, 1'b0);
    end

    // R12 overrun
    rx_trig = 2'b11; exp_q.delete();
    for (int i = 0; i < 8; i++) begin
      b = rnd_byte(); exp_q.push_back(b); send_rx(b);
    end
    chk("R12 no overrun at full", overrun, 1'b0);
    send_rx(rnd_byte());
    chk("R12 overrun set", overrun, 1'b1);
    while (exp_q.size() > 0) pop_rx("R12 kept bytes", exp_q.pop_front());
    cyc(1);
    chk("R12 new byte dropped", rx_valid, 1'b0);
    @(negedge clk); ovr_ack = 1'b1; @(negedge clk); ovr_ack = 1'b0;
    cyc(1);
    chk("R12 ack clears", overrun, 1'b0);

    // R9 queueing disabled
    fifo_en = 1'b0;
    b = rnd_byte(); send_rx(b);
    chk("R9 level is one", irq_rx_avail, 1'b1);
    send_rx(rnd_byte());
    chk("R9 second byte overruns", overrun, 1'b1);
    pop_rx("R9 holding byte", b);
    cyc(1);
    chk("R9 holding empty", rx_valid, 1'b0);
    @(negedge clk); ovr_ack = 1'b1; @(negedge clk); ovr_ack = 1'b0;
    mon_q.delete();
    cts_n = 1'b1; cyc(5);
    b = rnd_byte(); push_tx(b);
    cyc(2);
    chk("R9 tx holds one byte", tx_ready, 1'b0);
    cts_n = 1'b0;
    cyc(450);
    chk("R9 tx byte sent", (mon_q.size() > 0) ? mon_q[0] : 8'hxx, b);
    fifo_en = 1'b1;

    // R10 timeout
    rx_trig = 2'b11;
    b = rnd_byte(); send_rx(b);
    cyc(1200);
    chk("R10 no timeout yet", irq_rx_tout, 1'b0);
    cyc(120);
    chk("R10 timeout fires", irq_rx_tout, 1'b1);
    pop_rx("R10 timed-out byte", b);
    chk("R10 pop clears", irq_rx_tout, 1'b0);
    b = rnd_byte(); b2 = rnd_byte();
    send_rx(b); cyc(800); send_rx(b2); cyc(800);
    chk("R10 reload on char", irq_rx_tout, 1'b0);
    cyc(600);
    chk("R10 fires after reload", irq_rx_tout, 1'b1);
    pop_rx("R10 first", b);
    chk("R10 reload on pop", irq_rx_tout, 1'b0);
    pop_rx("R10 second", b2);

    // R8 receive flush
    for (int i = 0; i < 3; i++) send_rx(rnd_byte());
    pulse_rx_flush();
    cyc(1);
    chk("R8 rx flush empties", rx_valid, 1'b0);
    b = rnd_byte();
    fork
      send_rx(b);
      begin cyc(100); pulse_rx_flush(); end
    join
    pop_rx("R8 char survives flush", b);

    cyc(10);
    finish_run();
  end
endmodule